// File: doc/BRIEF.md
# Sigma-Delta Serial Channel Receiver

This block is the input stage of one channel of a sigma-delta conversion path. It takes the one-bit stream produced by an external modulator and hands a downstream decimation filter one decoded bit per modulator sample. The bit is a +1/-1 code with a one-cycle valid strobe in the system clock domain.

Two line codings are handled. The first is a two-wire form: a bit clock plus a data line, with the data sampled on a selectable edge of the clock. The second is a single-wire Manchester form, from which the bit timing is recovered by measuring the intervals between transitions with the system clock. In the two-wire form the bit clock can come from four places:
- an external clock pin;
- the internally generated modulator clock;
- that internal clock halved by a divider advanced on its falling edges;
- that internal clock halved by a divider advanced on its rising edges.

An alternate-input select takes the data from the neighbouring channel's data pin. A channel enable gates the whole receiver. Clearing the enable also resets its edge history and the Manchester timing estimate.

Top module: `sd_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, bit_vld_o is 0 and bit_o is 2'b00.
- R2: While enable_i is 0 no bit is produced. Edge detectors follow the lines while disabled, so setting enable_i while the bit clock is already high yields no bit.
- R3: Each valid bit carries bit_o = 2'b01 for a logic 1 (+1) and 2'b11 for a logic 0 (-1). bit_o is 2'b00 whenever bit_vld_o is 0.
- R4: With if_type_i = 0 the data line is sampled on each rising edge of the selected bit clock, and falling edges produce nothing.
- R5: With if_type_i = 1 the data line is sampled on each falling edge of the selected bit clock, and rising edges produce nothing.
- R6: clk_src_i = 0 selects ext_clk_i as bit clock, and clk_src_i = 1 selects int_clk_i directly.
- R7: clk_src_i = 2 and 3 use int_clk_i halved by a divider that starts low at enable. For source 2 the divider toggles on each int_clk_i falling edge, and for source 3 on each rising edge. The edge chosen by if_type_i is then taken on the halved clock.
- R8: alt_in_i = 1 takes the serial data from dat_nb_i instead of dat_i.
- R9: With if_type_i = 2 or 3 (Manchester) a rising mid-bit transition decodes to 0 and a falling one to 1.
- R10: In Manchester mode the first transition after enable only starts timing. A later transition is accepted as mid-bit only once at least 3/4 of the current period estimate has elapsed since the last accepted one. Each accepted transition emits a bit and sets the period estimate to the measured interval. Locking requires the first two bits of a stream to differ.
- R11: Clearing enable_i discards the Manchester period estimate, so a stream at a different bit rate decodes correctly after re-enabling.
- R12: Exactly one single-cycle bit_vld_o pulse is produced per decoded bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| if_type_i | input | 2 | Line coding: 0 two-wire rising, 1 two-wire falling, 2/3 Manchester |
| clk_src_i | input | 2 | Bit clock: 0 external, 1 internal, 2 internal/2 on falling, 3 internal/2 on rising |
| alt_in_i | input | 1 | Take data from the neighbour's pin |
| ext_clk_i | input | 1 | External bit clock pin |
| int_clk_i | input | 1 | Internally generated modulator clock |
| dat_i | input | 1 | Own serial data pin |
| dat_nb_i | input | 1 | Neighbouring channel's serial data pin |
| bit_vld_o | output | 1 | One-cycle strobe per decoded bit |
| bit_o | output | 2 | Decoded bit as +1 (2'b01) or -1 (2'b11), 2'b00 when idle |

## Verification
The assertions take two things for granted. Every serial line and clock input holds each level for at least two system clock cycles, and the configuration inputs change only while enable_i is low. Without these, two accepted edges could fall in adjacent cycles. The stimulus holds every pin level for four or more cycles in the two-wire modes and for at least four cycles per Manchester half-bit. It changes if_type_i, clk_src_i and alt_in_i only with the channel disabled.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;

  typedef enum logic [1:0] {
    CS_EXT   = 2'd0,
    CS_INT   = 2'd1,
    CS_DIV_F = 2'd2,
    CS_DIV_R = 2'd3
  } clk_src_e;

  localparam logic [1:0] PM_POS  = 2'b01;
  localparam logic [1:0] PM_NEG  = 2'b11;
  localparam logic [1:0] PM_NONE = 2'b00;

  function automatic logic [1:0] pm_code(input logic b);
    return b ? PM_POS : PM_NEG;
  endfunction

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sd_spi_front.sv
module sd_spi_front
  import sd_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  clk_src_e src_i,
  input  logic     fall_i,
  input  logic     ext_clk_i,
  input  logic     int_clk_i,
  input  logic     dat_i,
  output logic     vld_o,
  output logic     bit_o
);
  logic int_prev_q, div_q, bclk_prev_q, vld_q, bit_q;
  logic int_rise, int_fall, div_tick, bclk, hit;

  assign int_rise = int_clk_i & ~int_prev_q;
  assign int_fall = ~int_clk_i & int_prev_q;

  always_comb begin
    div_tick = 1'b0;
    bclk     = ext_clk_i;
    unique case (src_i)
      CS_EXT:   bclk = ext_clk_i;
      CS_INT:   bclk = int_clk_i;
      CS_DIV_F: begin bclk = div_q; div_tick = int_fall; end
      CS_DIV_R: begin bclk = div_q; div_tick = int_rise; end
      default:  bclk = ext_clk_i;
    endcase
  end

  assign hit = fall_i ? (~bclk & bclk_prev_q) : (bclk & ~bclk_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_prev_q  <= 1'b0;
      div_q       <= 1'b0;
      bclk_prev_q <= 1'b0;
      vld_q       <= 1'b0;
      bit_q       <= 1'b0;
    end else begin
      int_prev_q  <= int_clk_i;
      bclk_prev_q <= bclk;  // tracks the line while disabled: no false edge at enable
      vld_q       <= en_i & hit;
      if (!en_i)         div_q <= 1'b0;
      else if (div_tick) div_q <= ~div_q;
      if (en_i && hit)   bit_q <= dat_i;
    end
  end

  assign vld_o = vld_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/sd_manch_dec.sv
module sd_manch_dec #(
  parameter int PER_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dat_i,
  output logic vld_o,
  output logic bit_o
);
  localparam logic [PER_W-1:0] CNT_ONE = PER_W'(1);
  localparam logic [PER_W-1:0] CNT_SAT = '1;

  logic             d_prev_q, seen_q, vld_q, bit_q;
  logic [PER_W-1:0] per_q, cnt_q, thr;
  logic             trans, accept;

  assign thr    = per_q - (per_q >> 2);  // 3/4 of the period estimate
  assign trans  = dat_i ^ d_prev_q;
  assign accept = trans & seen_q & ((per_q == '0) | (cnt_q >= thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_prev_q <= 1'b0;
      seen_q   <= 1'b0;
      vld_q    <= 1'b0;
      bit_q    <= 1'b0;
      per_q    <= '0;
      cnt_q    <= '0;
    end else begin
      d_prev_q <= dat_i;
      if (!en_i) begin
        seen_q <= 1'b0;
        vld_q  <= 1'b0;
        per_q  <= '0;
        cnt_q  <= '0;
      end else begin
        vld_q <= accept;
        if (accept) bit_q <= ~dat_i;  // falling mid-bit -> 1
        if (trans && !seen_q) begin
          seen_q <= 1'b1;
          cnt_q  <= CNT_ONE;
        end else if (accept) begin
          per_q <= cnt_q;
          cnt_q <= CNT_ONE;
        end else if (cnt_q != CNT_SAT) begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end

  assign vld_o = vld_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/sd_serial_rx.sv
module sd_serial_rx
  import sd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PER_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic [1:0] if_type_i,
  input  logic [1:0] clk_src_i,
  input  logic       alt_in_i,
  input  logic       ext_clk_i,
  input  logic       int_clk_i,
  input  logic       dat_i,
  input  logic       dat_nb_i,
  output logic       bit_vld_o,
  output logic [1:0] bit_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pin_s;
  logic            ext_s, int_s, own_s, nb_s, dat_sel;
  logic            man_mode, spi_vld, spi_bit, man_vld, man_bit;

  // internal clock shares the synchroniser so it stays aligned with data
  sd_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_clk_i, int_clk_i, dat_i, dat_nb_i}),
    .q_o   (pin_s)
  );
  assign {ext_s, int_s, own_s, nb_s} = pin_s;

  assign dat_sel  = alt_in_i ? nb_s : own_s;
  assign man_mode = if_type_i[1];

  sd_spi_front u_spi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i & ~man_mode),
    .src_i    (clk_src_e'(clk_src_i)),
    .fall_i   (if_type_i[0]),
    .ext_clk_i(ext_s),
    .int_clk_i(int_s),
    .dat_i    (dat_sel),
    .vld_o    (spi_vld),
    .bit_o    (spi_bit)
  );

  sd_manch_dec #(.PER_W(PER_W)) u_man (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (enable_i & man_mode),
    .dat_i (dat_sel),
    .vld_o (man_vld),
    .bit_o (man_bit)
  );

  assign bit_vld_o = spi_vld | man_vld;
  assign bit_o     = man_vld ? pm_code(man_bit) :
                     spi_vld ? pm_code(spi_bit) : PM_NONE;
endmodule

// File: rtl/sd_serial_rx_chk.sv
module sd_serial_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       bit_vld_o,
  input logic [1:0] bit_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!bit_vld_o && bit_o == 2'b00)
        else $error("R1: output active in reset");
    end
  end

  a_r2_off_no_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !bit_vld_o);

  a_r3_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> (bit_o == 2'b01 || bit_o == 2'b11));

  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_o |-> bit_o == 2'b00);

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |=> !bit_vld_o);
endmodule

bind sd_serial_rx sd_serial_rx_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .bit_vld_o(bit_vld_o),
  .bit_o    (bit_o)
);

// File: tb/sd_serial_rx_tb_top.sv
module sd_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] if_type = 2'd0;
  logic [1:0] clk_src = 2'd0;
  logic       alt = 1'b0;
  logic       ext_clk = 1'b0;
  logic       int_clk = 1'b0;
  logic       dat = 1'b0;
  logic       dat_nb = 1'b0;
  logic       bit_vld;
  logic [1:0] bit_val;

  int errors = 0;
  int checks = 0;
  int n_vld = 0;
  int n_exp = 0;
  bit done = 1'b0;
  logic vld_prev = 1'b0;
  string cur_req = "R1";

  logic [1:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  sd_serial_rx dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .enable_i (enable),
    .if_type_i(if_type),
    .clk_src_i(clk_src),
    .alt_in_i (alt),
    .ext_clk_i(ext_clk),
    .int_clk_i(int_clk),
    .dat_i    (dat),
    .dat_nb_i (dat_nb),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val)
  );

  // monitor
  always @(negedge clk) begin : mon
    logic [1:0] e;
    string r;
    if (rst_ni) begin
      if (bit_vld) begin
        n_vld++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected bit, actual %b expected none", cur_req, bit_val);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (bit_val !== e) begin  // R3 code check
            errors++;
            $display("FAIL %s: actual %b expected %b", r, bit_val, e);
          end
        end
        if (vld_prev) begin
          checks++;
          errors++;
          $display("FAIL R12: valid held, actual 2 cycles expected 1");
        end
      end else if (bit_val !== 2'b00) begin
        checks++;
        errors++;
        $display("FAIL R3: idle code actual %b expected 00", bit_val);
      end
      vld_prev <= bit_vld;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_exp(input logic b, input string r);
    exp_q.push_back(b ? 2'b01 : 2'b11);
    req_q.push_back(r);
    n_exp++;
  endtask

  task automatic drain(input string r);
    wait_n(40);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: bits missing, actual %0d pending expected 0", r, exp_q.size());
      exp_q.delete();
      req_q.delete();
    end
  endtask

  task automatic set_bclk(input logic use_int, input logic v);
    if (use_int) int_clk = v;
    else ext_clk = v;
  endtask

  // two-wire: sampling edge is idle -> active
  task automatic spi_bits(input logic [15:0] pat, input int n, input logic use_int,
                          input logic idle, input logic use_alt, input string r);
    cur_req = r;
    for (int i = 0; i < n; i++) begin
      if (use_alt) begin dat_nb = pat[i]; dat = ~pat[i]; end
      else begin dat = pat[i]; dat_nb = ~pat[i]; end
      push_exp(pat[i], r);
      wait_n(4);
      set_bclk(use_int, ~idle);
      wait_n(4);
      set_bclk(use_int, idle);
      wait_n(4);
    end
  endtask

  // halved internal clock: src 3 samples at the first int rise, src 2 at the first int fall
  task automatic div_bits(input logic [15:0] pat, input int n, input logic [1:0] src,
                          input string r);
    cur_req = r;
    for (int i = 0; i < n; i++) begin
      dat = pat[i];
      push_exp((src == 2'd3) ? pat[i] : ~pat[i], r);
      wait_n(4); int_clk = 1'b1;
      wait_n(4); dat = ~pat[i];
      wait_n(4); int_clk = 1'b0;
      wait_n(4); int_clk = 1'b1;
      wait_n(4); int_clk = 1'b0;
      wait_n(4);
    end
  endtask

  // Manchester: first half = bit value, mid transition 1->0 for a 1
  task automatic man_bits(input logic [15:0] pat, input int n, input int h,
                          input logic [1:0] mode, input string r);
    cur_req = r;
    enable  = 1'b0;
    if_type = mode;
    dat     = pat[0];
    wait_n(4);
    enable = 1'b1;
    wait_n(6);
    for (int i = 0; i < n; i++) begin
      dat = pat[i];
      wait_n(h);
      dat = ~pat[i];
      if (i > 0) push_exp(pat[i], r);  // R10: first transition only starts timing
      wait_n(h);
    end
  endtask

  initial begin
    wait_n(5);
    checks++;  // R1
    if (bit_vld !== 1'b0 || bit_val !== 2'b00) begin
      errors++;
      $display("FAIL R1: actual vld=%b bit=%b expected vld=0 bit=00", bit_vld, bit_val);
    end
    rst_ni = 1'b1;
    wait_n(4);
    checks++;  // R1 after release
    if (bit_vld !== 1'b0 || bit_val !== 2'b00) begin
      errors++;
      $display("FAIL R1: actual vld=%b bit=%b expected vld=0 bit=00", bit_vld, bit_val);
    end

    // R4: external clock, rising edge
    if_type = 2'd0; clk_src = 2'd0; ext_clk = 1'b0;
    wait_n(3); enable = 1'b1; wait_n(3);
    spi_bits(16'hA5C3, 16, 1'b0, 1'b0, 1'b0, "R4");
    drain("R4");
    enable = 1'b0; wait_n(3);

    // R5: external clock, falling edge; enabled while clock high
    if_type = 2'd1; ext_clk = 1'b1;
    wait_n(3); enable = 1'b1; wait_n(3);
    spi_bits(16'h3C69, 12, 1'b0, 1'b1, 1'b0, "R5");
    drain("R5");
    enable = 1'b0; ext_clk = 1'b0; wait_n(3);

    // R6: internal clock direct
    if_type = 2'd0; clk_src = 2'd1; int_clk = 1'b0;
    wait_n(3); enable = 1'b1; wait_n(3);
    spi_bits(16'h9E21, 12, 1'b1, 1'b0, 1'b0, "R6");
    drain("R6");
    enable = 1'b0; wait_n(3);

    // R7: halved internal clock, rising then falling divider phase
    clk_src = 2'd3;
    wait_n(3); enable = 1'b1; wait_n(3);
    div_bits(16'h00B2, 8, 2'd3, "R7");
    drain("R7");
    enable = 1'b0; wait_n(3);
    clk_src = 2'd2;
    wait_n(3); enable = 1'b1; wait_n(3);
    div_bits(16'h006D, 8, 2'd2, "R7");
    drain("R7");
    enable = 1'b0; wait_n(3);

    // R8: neighbour data pin
    clk_src = 2'd0; alt = 1'b1;
    wait_n(3); enable = 1'b1; wait_n(3);
    spi_bits(16'h5A0F, 12, 1'b0, 1'b0, 1'b1, "R8");
    drain("R8");
    enable = 1'b0; alt = 1'b0; wait_n(3);

    // R2: disabled lines toggle; then enable with clock high
    cur_req = "R2";
    for (int i = 0; i < 10; i++) begin
      dat = ~dat; ext_clk = ~ext_clk; wait_n(4);
    end
    ext_clk = 1'b1; wait_n(4);
    enable = 1'b1; wait_n(8);
    ext_clk = 1'b0; wait_n(8);
    drain("R2");
    checks++;
    if (n_vld != n_exp) begin
      errors++;
      $display("FAIL R2: valid pulses actual %0d expected %0d", n_vld, n_exp);
    end
    enable = 1'b0; wait_n(3);

    // R9 / R10: Manchester, both modes and rates
    man_bits(16'h3A5D, 16, 8, 2'd2, "R9");
    drain("R9");
    man_bits(16'hC3E6, 16, 6, 2'd3, "R10");
    drain("R10");

    // R11: re-lock to a faster rate after disable
    man_bits(16'h0665, 12, 9, 2'd2, "R11");
    drain("R11");
    man_bits(16'hB4A9, 16, 4, 2'd2, "R11");
    drain("R11");
    enable = 1'b0; wait_n(5);

    checks++;  // R12: one pulse per expected bit overall
    if (n_vld != n_exp) begin
      errors++;
      $display("FAIL R12: valid pulses actual %0d expected %0d", n_vld, n_exp);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule